// File: doc/BRIEF.md
# Pipelined Fractional Complex Multiplier

This block forms the product of two complex operands, X and Y. Each operand has a real part and an imaginary part, and each part is a 16-bit two's complement fraction. The block is fully pipelined and takes a new operand pair on every clock. Each operand register has its own load enable, so one operand can stay fixed while the other streams. Either operand can be conjugated on the fly.

Each of the four real cross products is trapped, so that minus one times minus one gives the largest positive fraction. The results are 32-bit fractions with two integer bits. The upper half of each result can optionally be rounded. A valid flag and an error flag leave the pipeline together with the data they belong to, three clocks after the operands are captured.

Top module: `frac_cmul`

## Requirements
- R1: Operand parts are Q1.15 fractions: bit 15 has weight -1, and bits 14..0 have weights 2^-1 down to 2^-15. The outputs are 32-bit fractions with LSB weight 2^-30: `out_re = XR*YR - XI*YI` and `out_im = XR*YI + XI*YR`. Each cross product is 31 bits before it is sign-extended.
- R2: A new operation can start on every clock. Back-to-back operations produce back-to-back results, in order.
- R3: The X part registers load only when `x_en` is high, and the Y part registers load only when `y_en` is high. When an enable is low, that register keeps its earlier value. `conj_x`, `conj_y`, `rnd` and `in_valid` are captured on every clock.
- R4: A cross product whose two factors are both 0x8000 is replaced by 0x3FFFFFFF.
- R5: `conj_x` high negates the imaginary part of X. `conj_y` high negates the imaginary part of Y.
- R6: Negating an imaginary part of 0x8000 gives 0x7FFF.
- R7: When `conj_x` and `conj_y` are both high, neither operand is conjugated. `out_err` is high on that operation's result cycle only, and only when that operation is valid.
- R8: With `rnd` high, bit 16 of both results is forced to 1. All other bits are unchanged.
- R9: A synchronous active-high `rst` clears every pipeline register. While reset is applied, all outputs read 0.
- R10: `out_valid` equals `in_valid` from three clocks earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks the current operand pair as an operation |
| x_en | input | 1 | Load enable of the X registers |
| y_en | input | 1 | Load enable of the Y registers |
| x_re | input | 16 | Real part of X |
| x_im | input | 16 | Imaginary part of X |
| y_re | input | 16 | Real part of Y |
| y_im | input | 16 | Imaginary part of Y |
| conj_x | input | 1 | Conjugate X |
| conj_y | input | 1 | Conjugate Y |
| rnd | input | 1 | Round the upper 16 bits of both results |
| out_valid | output | 1 | A result is present |
| out_err | output | 1 | The result came from a conjugation clash |
| out_re | output | 32 | Real result |
| out_im | output | 32 | Imaginary result |

## Verification
The assertions watch the control path on every cycle after reset:
- the three-clock travel of the valid flag;
- the alignment of the clash flag with the operation that raised it;
- the forced bit 16 under rounding;
- the cleared outputs after reset.

The arithmetic itself is shown only by the bench's scenarios. These are the cross-product sums, the minus-one trap, saturated negation, hold behaviour with an enable low, and suppressed conjugation on a clash. The bench compares each of them against a model of held operand registers.

// File: rtl/cm_pkg.sv
package cm_pkg;
  localparam int NPROD = 4;
  localparam int IDX_RR = 0;
  localparam int IDX_RI = 1;
  localparam int IDX_IR = 2;
  localparam int IDX_II = 3;

  typedef struct packed {
    logic vld;
    logic err;
    logic rnd;
  } cm_ctl_t;
endpackage

// File: rtl/cm_conj.sv
module cm_conj #(
  parameter int W = 16
) (
  input  logic [W-1:0] v,
  input  logic         neg,
  output logic [W-1:0] o
);
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAXV = ~MINV;

  always_comb begin
    if (!neg)          o = v;
    else if (v == MINV) o = MAXV;
    else               o = ~v + W'(1);
  end
endmodule

// File: rtl/cm_fracmul.sv
module cm_fracmul #(
  parameter int W = 16,
  localparam int PW = 2*W-1
) (
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  output logic [PW-1:0]       p
);
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
  logic signed [2*W-1:0] full;
  logic trap;

  assign full = a * b;
  assign trap = (a == MINV) && (b == MINV);
  assign p    = trap ? {1'b0, {(PW-1){1'b1}}} : full[PW-1:0];
endmodule

// File: rtl/cm_addsub.sv
module cm_addsub #(
  parameter int W = 16,
  localparam int PW = 2*W-1,
  localparam int SW = 2*W
) (
  input  logic [PW-1:0] p_rr,
  input  logic [PW-1:0] p_ri,
  input  logic [PW-1:0] p_ir,
  input  logic [PW-1:0] p_ii,
  input  logic          rnd,
  output logic [SW-1:0] s_re,
  output logic [SW-1:0] s_im
);
  localparam logic [SW-1:0] RMASK = SW'(1) << W;
  logic [SW-1:0] e_rr, e_ri, e_ir, e_ii, raw_re, raw_im;

  assign e_rr = {p_rr[PW-1], p_rr};
  assign e_ri = {p_ri[PW-1], p_ri};
  assign e_ir = {p_ir[PW-1], p_ir};
  assign e_ii = {p_ii[PW-1], p_ii};

  assign raw_re = e_rr - e_ii;
  assign raw_im = e_ri + e_ir;
  assign s_re   = rnd ? (raw_re | RMASK) : raw_re;
  assign s_im   = rnd ? (raw_im | RMASK) : raw_im;
endmodule

// File: rtl/frac_cmul.sv
module frac_cmul #(
  parameter int DW = 16,
  localparam int PW = 2*DW-1,
  localparam int SW = 2*DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          x_en,
  input  logic          y_en,
  input  logic [DW-1:0] x_re,
  input  logic [DW-1:0] x_im,
  input  logic [DW-1:0] y_re,
  input  logic [DW-1:0] y_im,
  input  logic          conj_x,
  input  logic          conj_y,
  input  logic          rnd,
  output logic          out_valid,
  output logic          out_err,
  output logic [SW-1:0] out_re,
  output logic [SW-1:0] out_im
);
  import cm_pkg::*;

  // stage 1: operand and control capture
  logic [DW-1:0] xr_q, xi_q, yr_q, yi_q;
  logic cx_q, cy_q, v1_q, r1_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      xr_q <= '0; xi_q <= '0; yr_q <= '0; yi_q <= '0;
      cx_q <= 1'b0; cy_q <= 1'b0; v1_q <= 1'b0; r1_q <= 1'b0;
    end else begin
      if (x_en) begin
        xr_q <= x_re;
        xi_q <= x_im;
      end
      if (y_en) begin
        yr_q <= y_re;
        yi_q <= y_im;
      end
      cx_q <= conj_x;
      cy_q <= conj_y;
      v1_q <= in_valid;
      r1_q <= rnd;
    end
  end

  // conjugation, suppressed on a clash
  logic clash;
  logic [DW-1:0] xi_eff, yi_eff;
  assign clash = cx_q & cy_q;

  cm_conj #(.W(DW)) u_conj_x (.v(xi_q), .neg(cx_q & ~clash), .o(xi_eff));
  cm_conj #(.W(DW)) u_conj_y (.v(yi_q), .neg(cy_q & ~clash), .o(yi_eff));

  // stage 2: four trapped cross products
  logic signed [DW-1:0] ma [NPROD];
  logic signed [DW-1:0] mb [NPROD];
  logic [PW-1:0] prod [NPROD];
  logic [PW-1:0] p_q  [NPROD];
  cm_ctl_t c2_q;

  assign ma[IDX_RR] = xr_q;   assign mb[IDX_RR] = yr_q;
  assign ma[IDX_RI] = xr_q;   assign mb[IDX_RI] = yi_eff;
  assign ma[IDX_IR] = xi_eff; assign mb[IDX_IR] = yr_q;
  assign ma[IDX_II] = xi_eff; assign mb[IDX_II] = yi_eff;

  for (genvar k = 0; k < NPROD; k++) begin : g_mul
    cm_fracmul #(.W(DW)) u_mul (.a(ma[k]), .b(mb[k]), .p(prod[k]));
    always_ff @(posedge clk) begin
      if (rst) p_q[k] <= '0;
      else     p_q[k] <= prod[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) c2_q <= '0;
    else     c2_q <= '{vld: v1_q, err: v1_q & clash, rnd: r1_q};
  end

  // stage 3: sums, rounding, output registers
  logic [SW-1:0] s_re, s_im;
  cm_addsub #(.W(DW)) u_sum (
    .p_rr(p_q[IDX_RR]), .p_ri(p_q[IDX_RI]),
    .p_ir(p_q[IDX_IR]), .p_ii(p_q[IDX_II]),
    .rnd(c2_q.rnd), .s_re(s_re), .s_im(s_im)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
    end else begin
      out_valid <= c2_q.vld;
      out_err   <= c2_q.err;
      out_re    <= s_re;
      out_im    <= s_im;
    end
  end
endmodule

// File: rtl/frac_cmul_checker.sv
module frac_cmul_checker #(
  parameter int DW = 16,
  localparam int SW = 2*DW
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          conj_x,
  input logic          conj_y,
  input logic          rnd,
  input logic          out_valid,
  input logic          out_err,
  input logic [SW-1:0] out_re,
  input logic [SW-1:0] out_im
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst)           age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  a_r10_valid_latency: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  a_r7_err_aligned: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3) |-> (out_err == $past(in_valid && conj_x && conj_y, 3)));

  a_r7_err_needs_valid: assert property (@(posedge clk) disable iff (rst)
    out_err |-> out_valid);

  a_r8_round_bit: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && out_valid && $past(rnd, 3)) |-> (out_re[DW] && out_im[DW]));

  a_r9_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !out_err && out_re == '0 && out_im == '0));
endmodule

bind frac_cmul frac_cmul_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .conj_x(conj_x), .conj_y(conj_y),
  .rnd(rnd), .out_valid(out_valid), .out_err(out_err),
  .out_re(out_re), .out_im(out_im)
);

// File: tb/frac_cmul_bench.sv
module frac_cmul_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 0, x_en = 0, y_en = 0, conj_x = 0, conj_y = 0, rnd = 0;
  logic [15:0] x_re = 0, x_im = 0, y_re = 0, y_im = 0;
  logic out_valid, out_err;
  logic [31:0] out_re, out_im;

  always #2.5 clk = ~clk;

  frac_cmul u_frac_cmul (
    .clk(clk), .rst(rst), .in_valid(in_valid), .x_en(x_en), .y_en(y_en),
    .x_re(x_re), .x_im(x_im), .y_re(y_re), .y_im(y_im),
    .conj_x(conj_x), .conj_y(conj_y), .rnd(rnd),
    .out_valid(out_valid), .out_err(out_err), .out_re(out_re), .out_im(out_im)
  );

  int checks = 0;
  int failures = 0;
  logic [64:0] expq[$];
  string tagq[$];

  // model of the held operand registers
  int mxr = 0, mxi = 0, myr = 0, myi = 0;

  function automatic int sneg(int v);
    return (v == -32768) ? 32767 : -v;
  endfunction

  function automatic logic [31:0] prodf(int a, int b);
    if (a == -32768 && b == -32768) return 32'h3FFFFFFF;
    return 32'(a * b);
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] xr, xi, yr, yi,
                       input logic xe, ye, cx, cy, rd, vld, input string tag);
    int ex, ey;
    logic clash;
    logic [31:0] rr, ri, ir, ii, ere, eim;
    @(negedge clk);
    x_re = xr; x_im = xi; y_re = yr; y_im = yi;
    x_en = xe; y_en = ye; conj_x = cx; conj_y = cy; rnd = rd; in_valid = vld;
    if (xe) begin mxr = int'($signed(xr)); mxi = int'($signed(xi)); end
    if (ye) begin myr = int'($signed(yr)); myi = int'($signed(yi)); end
    clash = cx & cy;
    ex = (cx && !clash) ? sneg(mxi) : mxi;
    ey = (cy && !clash) ? sneg(myi) : myi;
    rr = prodf(mxr, myr); ri = prodf(mxr, ey);
    ir = prodf(ex, myr);  ii = prodf(ex, ey);
    ere = rr - ii;
    eim = ri + ir;
    if (rd) begin ere[16] = 1'b1; eim[16] = 1'b1; end
    if (vld) begin
      expq.push_back({clash, ere, eim});
      tagq.push_back(tag);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && out_valid) begin
        if (expq.size() == 0) begin
          checks++; failures++;
          $display("FAIL R10 unexpected out_valid actual=1 expected=0");
        end else begin
          logic [64:0] e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          chk(t, {out_re, out_im}, e[63:0]);
          chk({t, "/R7 err"}, {63'd0, out_err}, {63'd0, e[64]});
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R9: outputs cleared during reset
    repeat (3) @(negedge clk);
    chk("R9 reset", {out_re, out_im}, 64'd0);
    chk("R9 reset flags", {62'd0, out_valid, out_err}, 64'd0);
    @(negedge clk);
    rst = 1'b0;

    // R1: basic products
    drive(16'h4000, 16'h0000, 16'h4000, 16'h0000, 1,1,0,0,0,1, "R1 half*half");
    drive(16'h4000, 16'h2000, 16'hC000, 16'h6000, 1,1,0,0,0,1, "R1 mixed");
    drive(16'h7FFF, 16'h8001, 16'h1234, 16'hFEDC, 1,1,0,0,0,1, "R1 extremes");
    // R10: gap with in_valid low
    drive(16'h1111, 16'h2222, 16'h3333, 16'h4444, 1,1,0,0,0,0, "R10 idle");
    drive(16'h1111, 16'h2222, 16'h3333, 16'h4444, 1,1,0,0,0,0, "R10 idle");
    // R2: back-to-back stream
    for (int i = 0; i < 20; i++)
      drive(16'(i*3331), 16'(i*(-977)), 16'(16'h8000 + i*1201), 16'(i*4093),
            1,1,0,0,0,1, "R2 stream");
    // R3: hold X, change Y; then hold Y
    drive(16'h3000, 16'hD000, 16'h2000, 16'h1000, 1,1,0,0,0,1, "R3 load");
    drive(16'h7777, 16'h7777, 16'h0800, 16'hF800, 0,1,0,0,0,1, "R3 x held");
    drive(16'h0100, 16'h0200, 16'h7777, 16'h7777, 1,0,0,0,0,1, "R3 y held");
    // R4: minus one trap
    drive(16'h8000, 16'h0000, 16'h8000, 16'h0000, 1,1,0,0,0,1, "R4 trap re");
    drive(16'h8000, 16'h8000, 16'h8000, 16'h8000, 1,1,0,0,0,1, "R4 trap all");
    // R5: conjugation
    drive(16'h2000, 16'h4000, 16'h3000, 16'h1000, 1,1,1,0,0,1, "R5 conj x");
    drive(16'h2000, 16'h4000, 16'h3000, 16'h1000, 1,1,0,1,0,1, "R5 conj y");
    // R6: saturated negation
    drive(16'h4000, 16'h8000, 16'h4000, 16'h0000, 1,1,1,0,0,1, "R6 sat x");
    drive(16'h4000, 16'h0000, 16'h4000, 16'h8000, 1,1,0,1,0,1, "R6 sat y");
    // R7: clash
    drive(16'h2000, 16'h4000, 16'h3000, 16'h1000, 1,1,1,1,0,1, "R7 clash");
    drive(16'h2000, 16'h4000, 16'h3000, 16'h1000, 1,1,1,1,0,0, "R7 clash idle");
    drive(16'h2000, 16'h4000, 16'h3000, 16'h1000, 1,1,0,0,0,1, "R7 after");
    // R8: rounding
    drive(16'h4321, 16'h1357, 16'h2468, 16'h9ABC, 1,1,0,0,1,1, "R8 round");
    drive(16'h0001, 16'h0000, 16'h0001, 16'h0000, 1,1,0,0,1,1, "R8 round small");
    drive(16'h0001, 16'h0000, 16'h0001, 16'h0000, 1,1,0,0,0,1, "R8 no round");
    drive(0,0,0,0, 0,0,0,0,0,0, "idle");
    repeat (6) @(negedge clk);
    chk("R10 drained", 64'(expq.size()), 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule